// File: doc/BRIEF.md
# Four-Bit Arithmetic and Logic Unit with Operand and Result Inversion

This block combines two small operation groups behind one result port. The arithmetic group adds, subtracts, or shifts operand A by one place. The logic group applies a bitwise AND, OR, XOR or XNOR to the two operands. Each group has its own 2-bit operation code, and a group-select bit decides which group's value is passed on. Before a logic operation, either operand can be complemented. After the group choice, the chosen value can be complemented as a whole.

Two status flags come with the result. The carry flag reports the adder's carry-out for addition and the absence of a borrow for subtraction. The zero flag reports an all-zero final result. With the default parameter setting, the result and both flags are captured in an output register, so a datapath that feeds the block with new operands each cycle gets the answer one clock later.

Top module: `nib_alu`

## Requirements
- R1: With group select 0 and arithmetic code 00, the result is (A + B) mod 16 and carry is the carry-out of the 4-bit sum.
- R2: With group select 0 and arithmetic code 01, the result is (A - B) mod 16 and carry is 1 exactly when A >= B (unsigned).
- R3: With group select 0, code 10 gives {A[2:0], 0} and code 11 gives {A[3], A[3:1]}, and carry is 0 for both.
- R4: With group select 1, logic code 00 gives AND, 01 gives OR, 10 gives XOR and 11 gives XNOR of the operands, and carry is 0.
- R5: inv_a and inv_b complement A and B before a logic operation and have no effect on any arithmetic-group output.
- R6: When inv_y is 1, the result is the bitwise complement of the selected group's value for both groups, and carry is unchanged.
- R7: zero is 1 exactly when the final 4-bit result, after any output inversion, is 0000.
- R8: With REG_OUT = 1, res, carry and zero show the function of the inputs present at the previous rising clock edge and hold between edges. Reset drives res = 0000, carry = 0 and zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| arith_sel | input | 2 | Arithmetic operation code |
| logic_sel | input | 2 | Logic operation code |
| grp_logic | input | 1 | 0 selects the arithmetic group, 1 selects the logic group |
| inv_a | input | 1 | Complement A before the logic operation |
| inv_b | input | 1 | Complement B before the logic operation |
| inv_y | input | 1 | Complement the selected result |
| res | output | 4 | Result |
| carry | output | 1 | Carry / no-borrow flag |
| zero | output | 1 | Result-is-zero flag |

## Verification
On every cycle, the assertions check that zero agrees with the result and that carry is 0 for shifts and logic operations. They also check that subtraction's carry matches an unsigned comparison of the operands and that an arithmetic right shift keeps the sign bit. Only the bench's scenarios can show the actual operation values across every operand, code and inversion combination. The bench also shows that the operand inversions leave the arithmetic group untouched, and that the outputs change only at the clock edge after the inputs change.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  typedef enum logic [1:0] {
    AR_ADD = 2'b00,
    AR_SUB = 2'b01,
    AR_SHL = 2'b10,
    AR_SAR = 2'b11
  } arith_op_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'b00,
    LG_OR   = 2'b01,
    LG_XOR  = 2'b10,
    LG_XNOR = 2'b11
  } logic_op_e;
endpackage

// File: rtl/nib_arith_unit.sv
module nib_arith_unit
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  arith_op_e    op,
  output logic [W-1:0] y,
  output logic         co
);
  localparam int SW = W + 1;

  logic [W-1:0]  b_eff;
  logic          cin;
  logic [SW-1:0] sum;

  // one shared adder: subtraction is A + ~B + 1, carry-out means no borrow
  always_comb begin
    cin   = (op == AR_SUB);
    b_eff = cin ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  end

  always_comb begin
    y  = '0;
    co = 1'b0;
    unique case (op)
      AR_ADD, AR_SUB: begin
        y  = sum[W-1:0];
        co = sum[W];
      end
      AR_SHL: y = {a[W-2:0], 1'b0};
      AR_SAR: y = {a[W-1], a[W-1:1]};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/nib_logic_unit.sv
module nib_logic_unit
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic_op_e    op,
  output logic [W-1:0] y
);
  // one slice per bit: optional operand inversion, then the four functions
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ai, bi;
    assign ai = a[i] ^ inv_a;
    assign bi = b[i] ^ inv_b;
    always_comb begin
      unique case (op)
        LG_AND:  y[i] = ai & bi;
        LG_OR:   y[i] = ai | bi;
        LG_XOR:  y[i] = ai ^ bi;
        LG_XNOR: y[i] = ~(ai ^ bi);
        default: y[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/nib_out_stage.sv
module nib_out_stage #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] y_nxt,
  input  logic         c_nxt,
  input  logic         z_nxt,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         zero
);
  if (REG_OUT) begin : g_reg
    logic [W-1:0] res_q;
    logic         carry_q, zero_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q   <= '0;
        carry_q <= 1'b0;
        zero_q  <= 1'b1;
      end else begin
        res_q   <= y_nxt;
        carry_q <= c_nxt;
        zero_q  <= z_nxt;
      end
    end
    assign res   = res_q;
    assign carry = carry_q;
    assign zero  = zero_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign res   = y_nxt;
    assign carry = c_nxt;
    assign zero  = z_nxt;
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   arith_sel,
  input  logic [1:0]   logic_sel,
  input  logic         grp_logic,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic         inv_y,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         zero
);
  logic [W-1:0] ar_y, lg_y, sel_y, y_nxt;
  logic         ar_co, c_nxt, z_nxt;
  arith_op_e    ar_op;
  logic_op_e    lg_op;

  assign ar_op = arith_op_e'(arith_sel);
  assign lg_op = logic_op_e'(logic_sel);

  nib_arith_unit #(.W(W)) u_arith (
    .a(opa), .b(opb), .op(ar_op), .y(ar_y), .co(ar_co)
  );

  nib_logic_unit #(.W(W)) u_logic (
    .a(opa), .b(opb), .inv_a(inv_a), .inv_b(inv_b), .op(lg_op), .y(lg_y)
  );

  // next-state: group choice, output inversion, flags
  always_comb begin
    sel_y = grp_logic ? lg_y : ar_y;
    c_nxt = grp_logic ? 1'b0 : ar_co;
    y_nxt = inv_y ? ~sel_y : sel_y;
    z_nxt = (y_nxt == '0);
  end

  nib_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .y_nxt(y_nxt), .c_nxt(c_nxt), .z_nxt(z_nxt),
    .res(res), .carry(carry), .zero(zero)
  );

  // R2: subtract carry agrees with an unsigned compare of the operands
  p_sub_nob_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_op == AR_SUB) |-> (ar_co == (opa >= opb)));

  // R3: shifts never produce a carry
  p_shift_nocy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_logic && arith_sel[1]) |-> (c_nxt == 1'b0));

  // R3: arithmetic right shift keeps the sign bit
  p_sar_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_op == AR_SAR) |-> (ar_y[W-1] == opa[W-1]));

  // R4: logic group never produces a carry
  p_logic_nocy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grp_logic |-> (c_nxt == 1'b0));

  // R7: zero flag agrees with the visible result
  p_zero_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero == (res == '0));
endmodule

// File: tb/tb_nib_alu.sv
module tb_nib_alu;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] opa, opb;
  logic [1:0] arith_sel, logic_sel;
  logic       grp_logic, inv_a, inv_b, inv_y;
  logic [3:0] res;
  logic       carry, zero;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  nib_alu dut (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
    .arith_sel(arith_sel), .logic_sel(logic_sel), .grp_logic(grp_logic),
    .inv_a(inv_a), .inv_b(inv_b), .inv_y(inv_y),
    .res(res), .carry(carry), .zero(zero)
  );

  // reference: {carry, zero, res}
  function automatic logic [5:0] model(input logic [3:0] a, b, input logic [1:0] as, ls,
                                       input logic g, na, nb, ny);
    logic [4:0] t;
    logic [3:0] r, aa, bb;
    logic       c;
    c = 1'b0;
    r = 4'h0;
    if (!g) begin
      case (as)
        2'd0: begin t = {1'b0, a} + {1'b0, b}; r = t[3:0]; c = t[4]; end
        2'd1: begin r = a - b; c = (a >= b); end
        2'd2: r = {a[2:0], 1'b0};
        default: r = {a[3], a[3:1]};
      endcase
    end else begin
      aa = na ? ~a : a;
      bb = nb ? ~b : b;
      case (ls)
        2'd0: r = aa & bb;
        2'd1: r = aa | bb;
        2'd2: r = aa ^ bb;
        default: r = ~(aa ^ bb);
      endcase
    end
    if (ny) r = ~r;
    return {c, (r == 4'h0), r};
  endfunction

  function automatic string tag_of(input logic g, input logic [1:0] as);
    if (g) return "R4";
    case (as)
      2'd0: return "R1";
      2'd1: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got c=%b z=%b y=%h, expected c=%b z=%b y=%h",
               tag, act[5], act[4], act[3:0], exp[5], exp[4], exp[3:0]);
    end
  endtask

  // drive at negedge, result registered at next posedge, sampled at following negedge
  task automatic apply(input logic [3:0] a, b, input logic [1:0] as, ls,
                       input logic g, na, nb, ny, input string tag);
    @(negedge clk);
    opa = a; opb = b; arith_sel = as; logic_sel = ls;
    grp_logic = g; inv_a = na; inv_b = nb; inv_y = ny;
    @(negedge clk);
    check(tag, {carry, zero, res}, model(a, b, as, ls, g, na, nb, ny));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    opa = 4'h0; opb = 4'h0; arith_sel = 2'd0; logic_sel = 2'd0;
    grp_logic = 1'b0; inv_a = 1'b0; inv_b = 1'b0; inv_y = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset", {carry, zero, res}, 6'b010000);
    rst_n = 1'b1;
  endtask

  task automatic t_arith_sweep;
    for (int as = 0; as < 4; as++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int ny = 0; ny < 2; ny++)
            apply(4'(a), 4'(b), 2'(as), 2'd0, 1'b0, 1'b0, 1'b0, 1'(ny),
                  ny ? "R6" : tag_of(1'b0, 2'(as)));
  endtask

  task automatic t_logic_sweep;
    for (int ls = 0; ls < 4; ls++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int n = 0; n < 8; n++)
            apply(4'(a), 4'(b), 2'd0, 2'(ls), 1'b1, n[0], n[1], n[2],
                  n[1:0] != 0 ? "R5" : (n[2] ? "R6" : "R4"));
  endtask

  // R5: operand inversions must not change any arithmetic output
  task automatic t_neg_ignored_arith;
    logic [5:0] ref_v;
    for (int as = 0; as < 4; as++)
      for (int a = 0; a < 16; a += 3)
        for (int b = 0; b < 16; b += 5) begin
          ref_v = model(4'(a), 4'(b), 2'(as), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
          apply(4'(a), 4'(b), 2'(as), 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
          check("R5 arith unaffected", {carry, zero, res}, ref_v);
        end
  endtask

  task automatic t_zero_corners;
    apply(4'h8, 4'h8, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    check("R7 wrap add", {carry, zero, res}, 6'b110000);
    apply(4'h5, 4'h5, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    check("R7 equal sub", {carry, zero, res}, 6'b110000);
    apply(4'h3, 4'h4, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    check("R2 borrow", {carry, zero, res}, 6'b001111);
    apply(4'hF, 4'hF, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
    check("R7 inverted and", {carry, zero, res}, 6'b010000);
  endtask

  // R8: output holds until the next rising edge
  task automatic t_timing;
    apply(4'h1, 4'h2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    @(negedge clk);
    opa = 4'h7; opb = 4'h7; grp_logic = 1'b1; logic_sel = 2'd2;
    #2;
    check("R8 hold", {carry, zero, res}, 6'b000011);
    @(negedge clk);
    check("R8 update", {carry, zero, res}, 6'b010000);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_arith_sweep();
    t_logic_sweep();
    t_neg_ignored_arith();
    t_zero_corners();
    t_timing();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end
endmodule